// File: doc/BRIEF.md
# Single-Vector Message Interrupt Generator

This block sits beside a root-port function and converts its interrupt source into memory-write message requests. It handles one interrupt vector. Configuration inputs supply an enable, a trigger-mode select, a vector mask, a 32-bit message address and a 16-bit message data word. While message signalling is disabled, the interrupt appears on a legacy interrupt pin. While it is enabled, the legacy pin stays low, and every qualifying event produces a request on a valid/ready port. The request carries the address, the data and an assert/deassert level flag.

In edge mode, only a rising edge of the source counts as an event, and the flag always reads assert. In level mode, every change of the source counts as an event, and the flag carries the source state. A masked vector, or a request that is still waiting for acceptance, does not lose an event: a single pending bit records it. The pending bit is drained once the vector is unmasked and the port is idle. Two read-only capability outputs report that there is no 64-bit addressing and that only one message is available.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset, `reqValid` and `pendBit` are 0. `capAddr64` reads 0 and `capMultiMsg` reads 3'b000, the encoding for a single message.
- R2: When `cfgMsiEn`=0, `legacyIrq` equals `irqSrc` and no request is raised. When `cfgMsiEn`=1, `legacyIrq` is 0.
- R3: In edge mode (`cfgLevelMode`=0), a rising edge of `irqSrc` on an idle, unmasked vector raises `reqValid` one clock later with `reqLevel`=1. A falling edge raises nothing.
- R4: In level mode (`cfgLevelMode`=1), every change of `irqSrc` on an idle, unmasked vector raises a request one clock later. Its `reqLevel` equals the new source state: 1 means assert and 0 means deassert.
- R5: At launch, `reqAddr` and `reqData` take `cfgAddr` and `cfgData` without modification. Address, data and level hold stable while `reqValid`=1 and `reqReady`=0, even when the configuration changes.
- R6: Events that arrive while a request is outstanding set `pendBit`, and any number of them merge into one. After acceptance, exactly one further request is raised on the following clock, and `pendBit` clears.
- R7: While `cfgMask`=1, an event sets `pendBit` and raises no request. Clearing the mask with `pendBit`=1 raises one request on the next clock and clears `pendBit`.
- R8: Clearing `cfgMsiEn` drops both a pending event and an outstanding request. Both `pendBit` and `reqValid` are 0 on the next clock, and nothing is resent when the block is enabled again.
- R9: A level-mode request that comes from the pending bit carries the source state at the moment of launch.
- R10: An acceptance and a new event in the same clock leave `reqValid`=0 and `pendBit`=1, and the event is sent on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMsiEn | input | 1 | Message signalling enable |
| cfgLevelMode | input | 1 | 0 edge trigger, 1 level trigger |
| cfgMask | input | 1 | Vector mask |
| cfgAddr | input | ADDR_W | Message address |
| cfgData | input | DATA_W | Message data |
| irqSrc | input | 1 | Interrupt source state |
| reqReady | input | 1 | Downstream port accepts the request |
| reqValid | output | 1 | Request outstanding |
| reqAddr | output | ADDR_W | Request address |
| reqData | output | DATA_W | Request data |
| reqLevel | output | 1 | 1 assert, 0 deassert |
| pendBit | output | 1 | Pending bit of the vector |
| legacyIrq | output | 1 | Legacy interrupt pin |
| capAddr64 | output | 1 | 64-bit address capability (always 0) |
| capMultiMsg | output | 3 | Multiple-message capability (always single) |

## Verification
Acceptance of the outstanding request and arrival of a fresh source event can fall in the same clock. The bench provokes this by raising `irqSrc` in the very cycle it asserts `reqReady`. It then judges that `reqValid` drops while `pendBit` sets, and that exactly one request follows one clock later. A second collision pairs mask release with a pending bit and a new event. Here the bench checks that these produce one request, not two.

// File: rtl/msi_msg_pkg.sv
package msi_msg_pkg;
  typedef struct packed {
    logic launch;
    logic drop;
  } msiStrobe_t;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trigMode_e;
endpackage

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_msg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msiEn,
  input  logic       levelMode,
  input  logic       mask,
  input  logic       irqSrc,
  input  logic       reqReady,
  output logic       reqValid,
  output logic       pending,
  output logic       legacyIrq,
  output msiStrobe_t strobe
);
  logic srcQ;
  logic srcEvent;
  logic accept;
  logic want;

  always_comb begin
    if (trigMode_e'(levelMode) == TRIG_LEVEL) srcEvent = irqSrc ^ srcQ;
    else                                      srcEvent = irqSrc & ~srcQ;
    accept        = reqValid & reqReady;
    want          = srcEvent | pending;
    strobe.launch = msiEn & ~reqValid & ~mask & want;
    strobe.drop   = ~msiEn & (reqValid | pending);
    legacyIrq     = ~msiEn & irqSrc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ     <= 1'b0;
      reqValid <= 1'b0;
      pending  <= 1'b0;
    end else begin
      srcQ <= irqSrc;
      if (!msiEn) begin
        reqValid <= 1'b0;
        pending  <= 1'b0;
      end else if (reqValid) begin
        if (accept)   reqValid <= 1'b0;
        if (srcEvent) pending  <= 1'b1;
      end else if (strobe.launch) begin
        reqValid <= 1'b1;
        pending  <= 1'b0;
      end else if (srcEvent) begin
        pending <= 1'b1;
      end
    end
  end

  // R7: a masked idle vector never raises a request
  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msiEn && mask && !reqValid) |=> !reqValid);

  // R8: disabling clears both outstanding and pending state
  assert_disable_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    !msiEn |=> (!reqValid && !pending));

  // R7: unmasked pending on idle port is drained in one clock
  assert_pending_drain_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msiEn && !mask && pending && !reqValid) |=> (reqValid && !pending));

  // R6: an accepted request with nothing pending leaves the port idle
  assert_single_send_R6: assert property (@(posedge clk) disable iff (!rstN)
    (msiEn && reqValid && reqReady && !pending && !srcEvent) |=> (!reqValid && !pending));
endmodule

// File: rtl/msi_dpath.sv
module msi_dpath
  import msi_msg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  msiStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              levelMode,
  input  logic              irqSrc,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              reqLevel
);
  logic nextLevel;

  always_comb begin
    if (trigMode_e'(levelMode) == TRIG_LEVEL) nextLevel = irqSrc;
    else                                      nextLevel = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.drop) begin
      reqAddr  <= '0;
      reqData  <= '0;
      reqLevel <= 1'b0;
    end else if (strobe.launch) begin
      reqAddr  <= cfgAddr;
      reqData  <= cfgData;
      reqLevel <= nextLevel;
    end
  end

  // R5: launch and drop are never requested together
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.launch && strobe.drop));
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_msg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMsiEn,
  input  logic              cfgLevelMode,
  input  logic              cfgMask,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              irqSrc,
  input  logic              reqReady,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              reqLevel,
  output logic              pendBit,
  output logic              legacyIrq,
  output logic              capAddr64,
  output logic [2:0]        capMultiMsg
);
  localparam logic [2:0] ONE_MSG = 3'b000;

  msiStrobe_t strobe;

  assign capAddr64   = 1'b0;
  assign capMultiMsg = ONE_MSG;

  msi_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .msiEn     (cfgMsiEn),
    .levelMode (cfgLevelMode),
    .mask      (cfgMask),
    .irqSrc    (irqSrc),
    .reqReady  (reqReady),
    .reqValid  (reqValid),
    .pending   (pendBit),
    .legacyIrq (legacyIrq),
    .strobe    (strobe)
  );

  msi_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .levelMode (cfgLevelMode),
    .irqSrc    (irqSrc),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .reqLevel  (reqLevel)
  );

  // R5: an unaccepted request holds its contents
  assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMsiEn && reqValid && !reqReady) |=>
      (!cfgMsiEn || (reqValid && $stable(reqAddr) && $stable(reqData) && $stable(reqLevel))));

  // R3 / R4: level flag at launch follows the trigger mode
  assert_launch_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> (reqLevel == ($past(cfgLevelMode) ? $past(irqSrc) : 1'b1)));

  // R2: legacy pin silent while messages are enabled
  assert_legacy_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMsiEn && $past(cfgMsiEn)) |-> !legacyIrq);
endmodule

// File: tb/msi_msg_gen_test.sv
`timescale 1ns/1ps
module msi_msg_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0, lvl = 1'b0, msk = 1'b0, src = 1'b0, rdy = 1'b0;
  logic [31:0] addr = 32'hFEE0_1230;
  logic [15:0] data = 16'hA5C3;
  logic        reqValid, reqLevel, pendBit, legacyIrq, capAddr64;
  logic [31:0] reqAddr;
  logic [15:0] reqData;
  logic [2:0]  capMultiMsg;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  msi_msg_gen uut (
    .clk(clk), .rstN(rstN), .cfgMsiEn(en), .cfgLevelMode(lvl), .cfgMask(msk),
    .cfgAddr(addr), .cfgData(data), .irqSrc(src), .reqReady(rdy),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData), .reqLevel(reqLevel),
    .pendBit(pendBit), .legacyIrq(legacyIrq), .capAddr64(capAddr64),
    .capMultiMsg(capMultiMsg)
  );

  // row: {en,lvl,msk,src,rdy, expValid,expLevel,expPend,expLegacy}
  localparam logic [8:0] VEC [0:22] = '{
    9'b10000_0000, 9'b10010_1100, 9'b10010_1100, 9'b10000_1100,
    9'b10010_1110, 9'b10011_0010, 9'b10010_1100, 9'b10011_0000,
    9'b10100_0000, 9'b10110_0010, 9'b10100_0010, 9'b10000_1100,
    9'b10001_0000, 9'b11000_0000, 9'b11010_1100, 9'b11011_0000,
    9'b11000_1000, 9'b11010_1010, 9'b11011_0010, 9'b11010_1100,
    9'b11011_0000, 9'b00010_0001, 9'b00000_0000
  };
  localparam string VTAG [0:22] = '{
    "R3", "R3", "R3", "R3", "R6", "R6", "R6", "R6", "R7", "R7", "R7", "R7",
    "R7", "R4", "R4", "R4", "R4", "R6", "R6", "R9", "R9", "R2", "R2"
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chkState(input string tag, input logic v, input logic p, input logic lg);
    chk({tag, " reqValid"}, 32'(reqValid), 32'(v));
    chk({tag, " pendBit"}, 32'(pendBit), 32'(p));
    chk({tag, " legacyIrq"}, 32'(legacyIrq), 32'(lg));
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state and capability fields
    chkState("R1", 1'b0, 1'b0, 1'b0);
    chk("R1 capAddr64", 32'(capAddr64), 32'd0);
    chk("R1 capMultiMsg", 32'(capMultiMsg), 32'd0);

    for (int i = 0; i < 23; i++) begin
      {en, lvl, msk, src, rdy} = VEC[i][8:4];
      step();
      chkState(VTAG[i], VEC[i][3], VEC[i][1], VEC[i][0]);
      if (VEC[i][3]) chk({VTAG[i], " reqLevel"}, 32'(reqLevel), 32'(VEC[i][2]));
    end

    // R5: address/data captured unmodified and held while waiting
    en = 1; lvl = 0; msk = 0; rdy = 0; src = 0; step();
    src = 1; step();
    chk("R5 addr", reqAddr, 32'hFEE0_1230);
    chk("R5 data", 32'(reqData), 32'h0000_A5C3);
    addr = 32'h1234_5678; data = 16'h0F0F; step();
    chk("R5 addr hold", reqAddr, 32'hFEE0_1230);
    chk("R5 data hold", 32'(reqData), 32'h0000_A5C3);
    rdy = 1; step();
    chkState("R5 accept", 1'b0, 1'b0, 1'b0);
    rdy = 0; src = 0; step();

    // R6: several events while outstanding merge into one
    src = 1; step();
    chk("R6 launch", 32'(reqValid), 32'd1);
    src = 0; step();
    src = 1; step();
    src = 0; step();
    src = 1; step();
    chkState("R6 merged", 1'b1, 1'b1, 1'b0);
    rdy = 1; step();
    chkState("R6 accepted", 1'b0, 1'b1, 1'b0);
    rdy = 0; step();
    chkState("R6 resend", 1'b1, 1'b0, 1'b0);
    chk("R6 new addr", reqAddr, 32'h1234_5678);
    rdy = 1; step();
    rdy = 0; step();
    chkState("R6 only one", 1'b0, 1'b0, 1'b0);

    // R10: acceptance and new event in the same clock
    src = 0; step();
    src = 1; step();
    src = 0; step();
    src = 1; rdy = 1; step();
    chkState("R10 collide", 1'b0, 1'b1, 1'b0);
    rdy = 0; step();
    chkState("R10 follow", 1'b1, 1'b0, 1'b0);
    rdy = 1; step();
    rdy = 0; step();
    chkState("R10 idle", 1'b0, 1'b0, 1'b0);

    // R7 collision: unmask with pending plus a new event gives one request
    msk = 1; src = 0; step();
    src = 1; step();
    chkState("R7 masked", 1'b0, 1'b1, 1'b0);
    src = 0; step();
    msk = 0; src = 1; step();
    chkState("R7 unmask", 1'b1, 1'b0, 1'b0);
    rdy = 1; step();
    rdy = 0; step();
    chkState("R7 single", 1'b0, 1'b0, 1'b0);

    // R8: disable drops pending, then outstanding
    msk = 1; src = 0; step();
    src = 1; step();
    chk("R8 pend set", 32'(pendBit), 32'd1);
    en = 0; step();
    chkState("R8 drop pend", 1'b0, 1'b0, 1'b1);
    en = 1; msk = 0; step();
    chkState("R8 no resend", 1'b0, 1'b0, 1'b0);
    src = 0; step();
    src = 1; step();
    chk("R8 launch", 32'(reqValid), 32'd1);
    en = 0; step();
    chkState("R8 drop req", 1'b0, 1'b0, 1'b1);
    src = 0; step();
    chk("R2 legacy low", 32'(legacyIrq), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule